// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end and write state machine for a NOR-style flash array. Software talks to it with ordinary bus write cycles that carry a command byte (or a data word) and a word address. The block registers each write cycle before acting on it. From the command stream it chooses what a bus read returns: array contents, an identification word, or the status byte. It also runs the four operations that change the array: word program, block erase, whole-array erase and lock-bit set. It drives an external array write port to do this and handles the pulse and verify work itself, so software only has to poll the status byte.

Erase and program can be suspended and resumed. While an erase is suspended, the rest of the array can be read and programmed. While a program is suspended, other locations can be read. A supply-good input stands in for the programming voltage. When it is low, only the operations that change the array are refused. Reads of status and identification keep working.

The word address space uses a fixed bottom-boot layout with mixed block sizes. Operation length is set by a cycle-count parameter for programs and by one array write per cycle during erase. The command write port is valid/ready. `wr_ready` is held high at all times, so the port never applies back-pressure. Each cycle in which `wr_valid` is high delivers exactly one command or data word.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data (read-array mode), and the status byte reads 0x80: ready, with every error and suspend bit clear.
- R2: Every write cycle is registered before decoding. Command 0xFF selects array reads, 0x90 selects identification reads and 0x70 selects status reads. In identification mode, address bits [1:0] pick the word: 0 gives the maker code, 1 gives the device code, and 2 gives the lock bit of the block containing the address in bit 0. Status reads return the byte in rd_data[7:0] with: bit7 ready, bit6 erase suspended, bit5 erase/lock error, bit4 program error, bit3 supply low, bit2 program suspended, bit1 locked-block abort.
- R3: Status reads and identification reads return correct values while vpp_ok is low.
- R4: 0x40 followed by a data cycle writes that word at the data cycle's address after PROG_CYCLES cycles. Ready reads 0 until the write is done.
- R5: 0x20 then 0xD0 writes 0xFFFF to every word of the block that holds the second cycle's address, and to nothing else. The block map is fixed: eight 4K-word blocks below 0x08000 (two boot, then six parameter blocks), and fifteen 32K-word blocks on 0x8000 boundaries up to 0x7FFFF.
- R6: 0x30 then 0xD0 writes 0xFFFF over every block whose lock bit is clear and leaves locked blocks untouched.
- R7: If vpp_ok is low when an array-changing operation starts, no array write occurs. Bit3 is set, together with bit4 for a program or bit5 for an erase or lock.
- R8: A wrong second cycle (not 0xD0 after 0x20 or 0x30, not 0x01 after 0x60) sets bits 5 and 4. All error bits stay set through other commands until 0x50 clears them.
- R9: 0x60 then 0x01 sets the lock bit of the addressed block. A program or block erase aimed at a locked block aborts without array writes and sets bit1, plus bit4 (program) or bit5 (erase).
- R10: 0xB0 during an erase stops array writes and shows status 0xC0. While suspended, other blocks read normally and programs to other blocks complete. A program to the erasing block is refused with bit4. 0xD0 resumes the erase to completion.
- R11: 0xB0 during a program stops it with status 0x84. Other locations read normally, and 0xD0 resumes it so that the word is written.
- R12: While an operation is running, every command other than 0xB0 is ignored, including read-mode changes.
- R13: wr_ready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vpp_ok | input | 1 | Programming supply present |
| wr_valid | input | 1 | Bus write cycle present |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 19 | Word address of the write cycle |
| wr_data | input | 16 | Command byte in [7:0], or program data |
| rd_addr | input | 19 | Read word address |
| rd_data | output | 16 | Read result for the current read mode |
| arr_raddr | output | 19 | Array read address |
| arr_rdata | input | 16 | Array read data |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | 19 | Array write address |
| arr_wdata | output | 16 | Array write data |

## Verification
The program path is tried under three patterns: a plain program, a program suspended and resumed, and a program issued inside an erase suspension. Together these separate the normal path, the paused path and the nested path. Erase is tried on a boot block, on a suspended parameter block, and as a whole-array erase with all but one block locked. Counting array writes in each case exposes a wrong block range or a missing lock skip. Refusals are tried separately with the supply low, with a locked target and with a bad second cycle, so each error bit combination is attributed to one cause.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ADDR_W    = 19;
  localparam int DATA_W    = 16;
  localparam int SMALL_SH  = 12;
  localparam int MAIN_SH   = 15;
  localparam int N_SMALL   = 8;
  localparam int N_MAIN    = 15;
  localparam int N_BLK     = N_SMALL + N_MAIN;
  localparam int BLK_W     = $clog2(N_BLK + 1);
  localparam int SMALL_TOP = N_SMALL << SMALL_SH;

  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STAT    = 8'h70;
  localparam logic [7:0] CMD_CLR     = 8'h50;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CHIP    = 8'h30;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;
  localparam logic [7:0] CMD_GO      = 8'hD0;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_LOCK_OK = 8'h01;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rd_mode_t;
  typedef enum logic [2:0] {PD_NONE, PD_ERASE, PD_CHIP, PD_PROG, PD_LOCK} pend_t;

  typedef struct packed {
    logic vpp;
    logic ers;
    logic prg;
    logic lck;
  } err_set_t;

  function automatic logic is_small(input logic [ADDR_W-1:0] a);
    return a < ADDR_W'(SMALL_TOP);
  endfunction

  function automatic logic [BLK_W-1:0] blk_idx(input logic [ADDR_W-1:0] a);
    if (is_small(a)) return BLK_W'(a >> SMALL_SH);
    return BLK_W'(N_SMALL - 1) + BLK_W'(a >> MAIN_SH);
  endfunction

  function automatic logic [ADDR_W-1:0] blk_base(input logic [ADDR_W-1:0] a);
    if (is_small(a)) return (a >> SMALL_SH) << SMALL_SH;
    return (a >> MAIN_SH) << MAIN_SH;
  endfunction

  function automatic logic [ADDR_W-1:0] blk_last(input logic [ADDR_W-1:0] a);
    if (is_small(a)) return blk_base(a) | ADDR_W'((1 << SMALL_SH) - 1);
    return blk_base(a) | ADDR_W'((1 << MAIN_SH) - 1);
  endfunction
endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  logic [7:0] cmd_op,
  input  logic       busy,
  input  logic       esusp,
  input  logic       psusp,
  input  err_set_t   wsm_err,
  output rd_mode_t   mode_q,
  output logic       go_prog,
  output logic       go_erase,
  output logic       go_chip,
  output logic       go_lock,
  output logic       go_susp,
  output logic       go_resume,
  output err_set_t   err_q
);
  pend_t    pend_q, pend_n;
  rd_mode_t mode_n;
  logic     seq_err, clr;
  logic     in_susp;

  assign in_susp = esusp || psusp;

  always_comb begin
    go_prog = 1'b0; go_erase = 1'b0; go_chip = 1'b0; go_lock = 1'b0;
    go_susp = 1'b0; go_resume = 1'b0; seq_err = 1'b0; clr = 1'b0;
    pend_n = pend_q;
    mode_n = mode_q;
    if (cmd_vld && busy) begin
      if (cmd_op == CMD_SUSP) begin
        go_susp = 1'b1;
        mode_n  = RM_STATUS;
      end
    end else if (cmd_vld && pend_q != PD_NONE) begin
      pend_n = PD_NONE;
      mode_n = RM_STATUS;
      case (pend_q)
        PD_PROG:  go_prog = 1'b1;
        PD_ERASE: if (cmd_op == CMD_GO) go_erase = 1'b1; else seq_err = 1'b1;
        PD_CHIP:  if (cmd_op == CMD_GO) go_chip = 1'b1; else seq_err = 1'b1;
        PD_LOCK:  if (cmd_op == CMD_LOCK_OK) go_lock = 1'b1; else seq_err = 1'b1;
        default:  ;
      endcase
    end else if (cmd_vld) begin
      case (cmd_op)
        CMD_READ:  mode_n = RM_ARRAY;
        CMD_IDENT: mode_n = RM_IDENT;
        CMD_STAT:  mode_n = RM_STATUS;
        CMD_CLR:   clr = 1'b1;
        CMD_PROG:  if (!psusp) begin pend_n = PD_PROG; mode_n = RM_STATUS; end
        CMD_ERASE: if (!in_susp) begin pend_n = PD_ERASE; mode_n = RM_STATUS; end
        CMD_CHIP:  if (!in_susp) begin pend_n = PD_CHIP; mode_n = RM_STATUS; end
        CMD_LOCK:  if (!in_susp) begin pend_n = PD_LOCK; mode_n = RM_STATUS; end
        CMD_GO:    if (in_susp) begin go_resume = 1'b1; mode_n = RM_STATUS; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= RM_ARRAY;
      pend_q <= PD_NONE;
      err_q  <= '0;
    end else begin
      mode_q <= mode_n;
      pend_q <= pend_n;
      if (clr) begin
        err_q <= '0;
      end else begin
        err_q.vpp <= err_q.vpp | wsm_err.vpp;
        err_q.ers <= err_q.ers | wsm_err.ers | seq_err;
        err_q.prg <= err_q.prg | wsm_err.prg | seq_err;
        err_q.lck <= err_q.lck | wsm_err.lck;
      end
    end
  end

  // R8: an error bit only drops right after a clear command
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_q.prg) || $fell(err_q.ers)) |-> $past(clr));

  // R12: a running operation freezes read mode and pending state
  a_r12_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && busy && cmd_op != CMD_SUSP) |=> ($stable(mode_q) && $stable(pend_q)));
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              go_prog,
  input  logic              go_erase,
  input  logic              go_chip,
  input  logic              go_lock,
  input  logic              go_susp,
  input  logic              go_resume,
  output logic              busy,
  output logic              esusp,
  output logic              psusp,
  output err_set_t          err,
  output logic [N_BLK-1:0]  lock_q,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic              prog_act, prog_susp, erase_act, erase_susp, e_chip;
  logic [ADDR_W-1:0] p_addr, e_cur, e_last;
  logic [DATA_W-1:0] p_data;
  logic [CNT_W-1:0]  p_cnt;
  logic [BLK_W-1:0]  e_blk, a_idx, c_idx;
  logic [ADDR_W-1:0] a_base, a_last, c_last;
  logic              prog_run, erase_run, skip_blk, p_fin, e_fin;

  assign a_idx  = blk_idx(op_addr);
  assign a_base = blk_base(op_addr);
  assign a_last = blk_last(op_addr);
  assign c_idx  = blk_idx(e_cur);
  assign c_last = blk_last(e_cur);

  assign prog_run  = prog_act && !prog_susp;
  assign erase_run = erase_act && !erase_susp && !prog_act;
  assign skip_blk  = e_chip && lock_q[c_idx];
  assign p_fin     = prog_run && p_cnt == '0;
  assign e_fin     = erase_run && (skip_blk ? (c_last == e_last) : (e_cur == e_last));
  assign busy      = prog_run || (erase_act && !erase_susp);
  assign esusp     = erase_susp;
  assign psusp     = prog_susp;

  always_comb begin
    err = '0;
    if (go_prog) begin
      if (!vpp_ok)                          begin err.vpp = 1'b1; err.prg = 1'b1; end
      else if (lock_q[a_idx])               begin err.lck = 1'b1; err.prg = 1'b1; end
      else if (erase_act && a_idx == e_blk) err.prg = 1'b1;
    end
    if (go_erase) begin
      if (!vpp_ok)            begin err.vpp = 1'b1; err.ers = 1'b1; end
      else if (lock_q[a_idx]) begin err.lck = 1'b1; err.ers = 1'b1; end
    end
    if ((go_chip || go_lock) && !vpp_ok) begin err.vpp = 1'b1; err.ers = 1'b1; end
  end

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = p_addr;
    arr_wdata = p_data;
    if (p_fin) begin
      arr_we = 1'b1;
    end else if (erase_run && !skip_blk) begin
      arr_we    = 1'b1;
      arr_waddr = e_cur;
      arr_wdata = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_act <= 1'b0; prog_susp <= 1'b0; erase_act <= 1'b0; erase_susp <= 1'b0;
      e_chip <= 1'b0; p_addr <= '0; p_data <= '0; p_cnt <= '0;
      e_cur <= '0; e_last <= '0; e_blk <= '0; lock_q <= '0;
    end else begin
      if (go_prog && err == '0) begin
        prog_act <= 1'b1;
        p_addr   <= op_addr;
        p_data   <= op_data;
        p_cnt    <= CNT_W'(PROG_CYCLES - 1);
      end else if (prog_run) begin
        if (p_fin) prog_act <= 1'b0;
        else       p_cnt    <= p_cnt - 1'b1;
      end

      if (go_erase && err == '0) begin
        erase_act <= 1'b1; e_chip <= 1'b0;
        e_cur <= a_base; e_last <= a_last; e_blk <= a_idx;
      end else if (go_chip && err == '0) begin
        erase_act <= 1'b1; e_chip <= 1'b1;
        e_cur <= '0; e_last <= '1; e_blk <= BLK_W'(N_BLK);
      end else if (erase_run) begin
        if (e_fin)         erase_act <= 1'b0;
        else if (skip_blk) e_cur     <= c_last + 1'b1;
        else               e_cur     <= e_cur + 1'b1;
      end

      if (go_lock && err == '0) lock_q[a_idx] <= 1'b1;

      if (go_susp) begin
        if (prog_run && !erase_act && !p_fin) prog_susp  <= 1'b1;
        else if (erase_run && !e_fin)         erase_susp <= 1'b1;
      end
      if (go_resume) begin
        if (prog_susp)                    prog_susp  <= 1'b0;
        else if (erase_susp && !prog_act) erase_susp <= 1'b0;
      end
    end
  end

  // R10: a suspended erase leaves the array alone
  a_r10_no_write_esusp: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_susp && !prog_act) |-> !arr_we);

  // R11: a suspended program leaves the array alone
  a_r11_no_write_psusp: assert property (@(posedge clk) disable iff (!rst_n)
    prog_susp |-> !arr_we);

  // R11: never two suspensions at once
  a_r11_single_susp: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_susp && erase_susp));

  // R9: lock bits are never cleared
  a_r9_lock_keep: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R5: block erase writes stay inside the target block
  a_r5_erase_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && erase_run && !e_chip) |-> (c_idx == e_blk));

  // R7: no program is started with the supply low
  a_r7_vpp_block: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog && !vpp_ok && !prog_act) |=> !prog_act);
endmodule

// File: rtl/flash_rd_sel.sv
module flash_rd_sel
  import flash_cmd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0C7E
) (
  input  rd_mode_t          mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              busy,
  input  logic              esusp,
  input  logic              psusp,
  input  err_set_t          errs,
  input  logic [N_BLK-1:0]  lock_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [7:0] sr;

  assign sr = {!busy, esusp, errs.ers, errs.prg, errs.vpp, psusp, errs.lck, 1'b0};

  always_comb begin
    rd_data = arr_rdata;
    case (mode)
      RM_STATUS: rd_data = DATA_W'(sr);
      RM_IDENT: begin
        case (rd_addr[1:0])
          2'd0:    rd_data = MFR_CODE;
          2'd1:    rd_data = DEV_CODE;
          2'd2:    rd_data = DATA_W'(lock_q[blk_idx(rd_addr)]);
          default: rd_data = '0;
        endcase
      end
      default: rd_data = arr_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int                PROG_CYCLES = 20,
  parameter logic [DATA_W-1:0] MFR_CODE    = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_CODE    = 16'h0C7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);
  logic              lat_vld;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  rd_mode_t          mode;
  err_set_t          wsm_err, err_q;
  logic              busy, esusp, psusp;
  logic              go_prog, go_erase, go_chip, go_lock, go_susp, go_resume;
  logic [N_BLK-1:0]  lock_q;

  assign wr_ready  = 1'b1;
  assign arr_raddr = rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_vld  <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      lat_vld <= wr_valid;
      if (wr_valid) begin
        lat_addr <= wr_addr;
        lat_data <= wr_data;
      end
    end
  end

  flash_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_vld(lat_vld), .cmd_op(lat_data[7:0]),
    .busy(busy), .esusp(esusp), .psusp(psusp), .wsm_err(wsm_err),
    .mode_q(mode), .go_prog(go_prog), .go_erase(go_erase), .go_chip(go_chip),
    .go_lock(go_lock), .go_susp(go_susp), .go_resume(go_resume), .err_q(err_q)
  );

  flash_wsm #(.PROG_CYCLES(PROG_CYCLES)) u_wsm (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .op_addr(lat_addr), .op_data(lat_data),
    .go_prog(go_prog), .go_erase(go_erase), .go_chip(go_chip), .go_lock(go_lock),
    .go_susp(go_susp), .go_resume(go_resume), .busy(busy), .esusp(esusp),
    .psusp(psusp), .err(wsm_err), .lock_q(lock_q), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  flash_rd_sel #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .mode(mode), .rd_addr(rd_addr), .arr_rdata(arr_rdata), .busy(busy),
    .esusp(esusp), .psusp(psusp), .errs(err_q), .lock_q(lock_q), .rd_data(rd_data)
  );

  // R13: the write port never stalls
  a_r13_ready: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  // R1: leaving reset puts reads in array mode
  a_r1_reset_mode: assert property (@(posedge clk) !rst_n |=> (mode == RM_ARRAY));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_N = 20;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h0C7E;

  logic        clk = 1'b0, rst_n = 1'b0, vpp_ok = 1'b1, wr_valid = 1'b0;
  logic        wr_ready;
  logic [18:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, arr_rdata, arr_wdata;
  logic [18:0] arr_raddr, arr_waddr;
  logic        arr_we;

  int n_vec = 0, n_bad = 0, n_wr = 0;
  logic [15:0] mem [int];
  logic [18:0] q_addr[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYCLES(PROG_N), .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  function automatic logic [15:0] seed(input logic [18:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  always @(posedge clk) if (arr_we) begin
    mem[int'(arr_waddr)] = arr_wdata;
    n_wr++;
  end

  always @(arr_raddr or n_wr)
    arr_rdata = mem.exists(int'(arr_raddr)) ? mem[int'(arr_raddr)] : seed(arr_raddr);

  // monitor: pops expected reads and compares
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q_addr.size() != 0) begin
        rd_addr = q_addr[0];
        #1;
        n_vec++;
        if (rd_data !== q_exp[0]) begin
          n_bad++;
          $display("FAIL %s: rd_data=%h expected %h (addr %h)", q_tag[0], rd_data, q_exp[0], q_addr[0]);
        end
        void'(q_addr.pop_front());
        void'(q_exp.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  task automatic expect_rd(input logic [18:0] a, input logic [15:0] e, input string tag);
    q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(tag);
    while (q_addr.size() != 0) @(negedge clk);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (rd_data[7] !== 1'b1 && guard < 100000) begin @(negedge clk); guard++; end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    report();
  end

  initial begin : driver
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    expect_rd(19'h00000, seed(19'h00000), "R1 array mode after reset");
    cmd(0, 16'h0070);
    expect_rd(0, 16'h0080, "R1 status after reset");
    check_val("R13 wr_ready", int'(wr_ready), 1);
    // R2: identification reads
    cmd(0, 16'h0090);
    expect_rd(19'h00000, MFR, "R2 maker code");
    expect_rd(19'h00001, DEV, "R2 device code");
    expect_rd(19'h08002, 16'h0000, "R2 lock bit clear");
    // R3 / R7: supply low
    vpp_ok = 1'b0;
    expect_rd(19'h00001, DEV, "R3 ident with supply low");
    cmd(0, 16'h0070);
    expect_rd(0, 16'h0080, "R3 status with supply low");
    w0 = n_wr;
    cmd(19'h03000, 16'h0040);
    cmd(19'h03000, 16'h1234);
    repeat (PROG_N + 5) @(negedge clk);
    expect_rd(0, 16'h0098, "R7 program refused with supply low");
    check_val("R7 no array write", n_wr - w0, 0);
    cmd(0, 16'h00FF);
    expect_rd(19'h03000, seed(19'h03000), "R7 array unchanged");
    cmd(0, 16'h0050);
    cmd(0, 16'h0070);
    expect_rd(0, 16'h0080, "R8 clear status");
    vpp_ok = 1'b1;
    // R8: bad second cycle
    cmd(19'h01000, 16'h0020);
    cmd(19'h01000, 16'h0033);
    expect_rd(0, 16'h00B0, "R8 bad erase confirm");
    cmd(0, 16'h00FF);
    cmd(0, 16'h0070);
    expect_rd(0, 16'h00B0, "R8 errors sticky");
    cmd(0, 16'h0050);
    expect_rd(0, 16'h0080, "R8 cleared");
    // R4 / R12: program
    cmd(19'h03000, 16'h0040);
    cmd(19'h03000, 16'h1234);
    cmd(0, 16'h00FF);
    expect_rd(19'h03000, 16'h0000, "R12 read mode change ignored while busy");
    wait_ready();
    expect_rd(0, 16'h0080, "R4 program done");
    cmd(0, 16'h00FF);
    expect_rd(19'h03000, 16'h1234, "R4 programmed word");
    expect_rd(19'h03001, seed(19'h03001), "R4 neighbour untouched");
    // R5: boot block erase
    w0 = n_wr;
    cmd(19'h01800, 16'h0020);
    cmd(19'h01800, 16'h00D0);
    wait_ready();
    check_val("R5 erase write count", n_wr - w0, 4096);
    cmd(0, 16'h00FF);
    expect_rd(19'h01000, 16'hFFFF, "R5 block start erased");
    expect_rd(19'h01FFF, 16'hFFFF, "R5 block end erased");
    expect_rd(19'h00FFF, seed(19'h00FFF), "R5 lower block intact");
    expect_rd(19'h02000, seed(19'h02000), "R5 upper block intact");
    // R10: erase suspend
    cmd(19'h02000, 16'h0020);
    cmd(19'h02000, 16'h00D0);
    cmd(0, 16'h00B0);
    wait_ready();
    expect_rd(0, 16'h00C0, "R10 erase suspended status");
    w0 = n_wr;
    repeat (50) @(negedge clk);
    check_val("R10 no writes while suspended", n_wr - w0, 0);
    cmd(0, 16'h00FF);
    expect_rd(19'h05000, seed(19'h05000), "R10 read other block");
    cmd(19'h05000, 16'h0040);
    cmd(19'h05000, 16'hBEEF);
    wait_ready();
    expect_rd(0, 16'h00C0, "R10 still suspended after program");
    cmd(0, 16'h00FF);
    expect_rd(19'h05000, 16'hBEEF, "R10 program in other block");
    cmd(19'h02100, 16'h0040);
    cmd(19'h02100, 16'h4444);
    expect_rd(0, 16'h00D0, "R10 program to erasing block refused");
    cmd(0, 16'h0050);
    cmd(0, 16'h00D0);
    wait_ready();
    expect_rd(0, 16'h0080, "R10 erase resumed and done");
    cmd(0, 16'h00FF);
    expect_rd(19'h02FFF, 16'hFFFF, "R10 erase finished");
    expect_rd(19'h02100, 16'hFFFF, "R10 refused word erased");
    // R11: program suspend
    cmd(19'h06000, 16'h0040);
    cmd(19'h06000, 16'hCAFE);
    cmd(0, 16'h00B0);
    expect_rd(0, 16'h0084, "R11 program suspended status");
    cmd(0, 16'h00FF);
    expect_rd(19'h06001, seed(19'h06001), "R11 read other location");
    cmd(0, 16'h00D0);
    wait_ready();
    cmd(0, 16'h00FF);
    expect_rd(19'h06000, 16'hCAFE, "R11 resumed program written");
    // R9: lock bits
    cmd(19'h00000, 16'h0060);
    cmd(19'h00000, 16'h0001);
    expect_rd(0, 16'h0080, "R9 lock set ok");
    cmd(0, 16'h0090);
    expect_rd(19'h00002, 16'h0001, "R9 lock bit reads set");
    expect_rd(19'h01002, 16'h0000, "R9 neighbour lock clear");
    w0 = n_wr;
    cmd(19'h00010, 16'h0040);
    cmd(19'h00010, 16'h1111);
    expect_rd(0, 16'h0092, "R9 program to locked block");
    cmd(0, 16'h0050);
    cmd(19'h00000, 16'h0020);
    cmd(19'h00000, 16'h00D0);
    expect_rd(0, 16'h00A2, "R9 erase of locked block");
    check_val("R9 no writes to locked block", n_wr - w0, 0);
    cmd(0, 16'h0050);
    // R6: chip erase with all but one block locked
    for (int a = 'h2000; a <= 'h7000; a += 'h1000) begin
      cmd(19'(a), 16'h0060); cmd(19'(a), 16'h0001);
    end
    for (int a = 'h8000; a <= 'h78000; a += 'h8000) begin
      cmd(19'(a), 16'h0060); cmd(19'(a), 16'h0001);
    end
    w0 = n_wr;
    cmd(0, 16'h0030);
    cmd(0, 16'h00D0);
    wait_ready();
    expect_rd(0, 16'h0080, "R6 chip erase done");
    check_val("R6 only unlocked block written", n_wr - w0, 4096);
    cmd(0, 16'h00FF);
    expect_rd(19'h01000, 16'hFFFF, "R6 unlocked block erased");
    expect_rd(19'h03000, 16'h1234, "R6 locked block kept");
    expect_rd(19'h05000, 16'hBEEF, "R6 locked block kept");
    expect_rd(19'h7FFFF, seed(19'h7FFFF), "R6 top block kept");
    check_val("R13 wr_ready end", int'(wr_ready), 1);
    report();
  end
endmodule